// File: doc/BRIEF.md
# Tributary Pointer Interpreter

This block follows the pointer carried in the V1/V2 pair of a virtual-tributary superframe. Once per superframe an upstream aligner presents one 16-bit word, qualified by a single-cycle valid strobe. From the sequence of words the block decides where the payload starts. It tracks justification (increment and decrement) and jumps that a new-data flag announces. It declares path AIS when the word is all ones and loss of pointer when too many words are malformed. It also checks that the size code in the word matches the configured tributary type.

Configuration selects the tributary type, which is 1.5 or 2. It also selects the voting rule for justification bits and sets the number of consecutive invalid pointers tolerated before loss of pointer. Outputs are the accepted pointer, the current state, one-cycle increment and decrement strobes, level alarms for AIS, loss of pointer and size mismatch, and a one-cycle change flag for each alarm.

Top module: `vt_ptr_interp`

## Requirements
- R1: After reset the state is LOP (code 5), the pointer is 0, `lop_alarm` is 1 and every other alarm, strobe and change flag is 0.
- R2: The word holds the NDF field in bits 15:12, the size code in bits 11:10 and the pointer in bits 9:0. A pointer is valid when it is at most 103 (type 1.5) or 139 (type 2). Three consecutive valid words carrying the same pointer set the state to NORM (code 0) and load that pointer.
- R3: In an in-frame state (NORM, INC=1, DEC=2, NDF=3), a word whose I bits (pointer bits 9,7,5,3,1) are inverted against the accepted pointer enters INC, adds one and pulses `inc_evt`. The maximum value wraps to 0.
- R4: In an in-frame state, a word whose D bits (pointer bits 8,6,4,2,0) are inverted enters DEC, subtracts one and pulses `dec_evt`. The value 0 wraps to the maximum.
- R5: With `cfg_majority`=1 a justification needs at least 8 of the 10 I and D bits to agree with the pattern. With 0 it needs at least 3 of the 5 I bits and at least 3 of the 5 D bits to agree.
- R6: A word whose NDF field matches 1001 in at least 3 of its 4 bits and whose pointer is valid enters NDF and loads the pointer at once.
- R7: Three consecutive all-ones words enter AIS (code 4). All-ones words are not counted by the size check.
- R8: Consecutive invalid words, excluding justification and all-ones words, enter LOP once their count reaches `cfg_inv_limit`. A limit of 0 acts as 1.
- R9: In AIS or LOP a justification pattern has no effect on the pointer or strobes.
- R10: `size_alarm` rises on the third consecutive word whose size code differs from the expected one (11 for type 1.5, 10 for type 2). It clears on the next matching word.
- R11: `lop_chg`, `ais_chg` and `size_chg` pulse for exactly the cycle in which the matching alarm changes.
- R12: The pointer changes only in the cycle after a qualified word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | Qualifies `word_in` for one cycle |
| word_in | input | 16 | V1/V2 pointer word |
| cfg_vt2 | input | 1 | 1 selects tributary type 2, 0 selects type 1.5 |
| cfg_majority | input | 1 | 1 selects 8-of-10 voting, 0 selects 3-of-5 per group |
| cfg_inv_limit | input | 4 | Invalid words tolerated before LOP |
| ptr_out | output | 10 | Accepted pointer |
| state_out | output | 3 | Current state code |
| inc_evt | output | 1 | Increment strobe |
| dec_evt | output | 1 | Decrement strobe |
| ais_alarm | output | 1 | AIS state |
| lop_alarm | output | 1 | Loss-of-pointer state |
| size_alarm | output | 1 | Size mismatch alarm |
| ais_chg | output | 1 | AIS alarm changed |
| lop_chg | output | 1 | LOP alarm changed |
| size_chg | output | 1 | Size alarm changed |

## Verification
The properties assume that `cfg_vt2` does not shrink the valid range while a pointer is held. They also assume that configuration changes only between words, so that wrap arithmetic and range bounds can be checked against the current setting. The stimulus sets configuration only while `word_vld` is low and moves from type 1.5 to type 2, never back. Justification words are built by flipping exactly the I or D group of the accepted pointer. Plain words use the NDF field 0110, so no vote is decided by chance.

// File: rtl/vt_ptr_interp.sv
`timescale 1ns/1ps
module vt_ptr_interp #(
  parameter int PW    = 10,
  parameter int MAX_A = 103,
  parameter int MAX_B = 139
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_vld,
  input  logic [15:0]   word_in,
  input  logic          cfg_vt2,
  input  logic          cfg_majority,
  input  logic [3:0]    cfg_inv_limit,
  output logic [PW-1:0] ptr_out,
  output logic [2:0]    state_out,
  output logic          inc_evt,
  output logic          dec_evt,
  output logic          ais_alarm,
  output logic          lop_alarm,
  output logic          size_alarm,
  output logic          ais_chg,
  output logic          lop_chg,
  output logic          size_chg
);
  localparam int HALF = PW / 2;
  localparam int VOTE = HALF / 2 + 1;

  typedef enum logic [2:0] {S_NORM, S_INC, S_DEC, S_NDF, S_AIS, S_LOP} st_t;

  function automatic logic [PW-1:0] odd_mask();
    logic [PW-1:0] m;
    for (int k = 0; k < PW; k++) m[k] = ((PW - 1 - k) % 2) == 0;
    return m;
  endfunction
  localparam logic [PW-1:0] IMASK = odd_mask();

  st_t st_q, st_d;
  logic [PW-1:0] ptr_d, cand_q, cand_d;
  logic [1:0] ais_q, ais_d, cons_q, cons_d, mm_q, mm_d;
  logic [3:0] inv_q, inv_d;
  logic size_d, inc_d, dec_d;

  wire [3:0]    ndf_f = word_in[PW+5:PW+2];
  wire [1:0]    ss    = word_in[PW+1:PW];
  wire [PW-1:0] p     = word_in[PW-1:0];
  wire [PW-1:0] max_p = cfg_vt2 ? PW'(MAX_B) : PW'(MAX_A);
  wire [PW-1:0] diff  = p ^ ptr_out;
  int i_inv, d_inv;
  assign i_inv = $countones(diff & IMASK);
  assign d_inv = $countones(diff & ~IMASK);

  wire inc_hit = cfg_majority ? (i_inv + HALF - d_inv >= PW - 2)
                              : (i_inv >= VOTE && HALF - d_inv >= VOTE);
  wire dec_hit = cfg_majority ? (d_inv + HALF - i_inv >= PW - 2)
                              : (d_inv >= VOTE && HALF - i_inv >= VOTE);
  wire all_ones = &word_in;
  wire ndf_hit  = $countones(~(ndf_f ^ 4'b1001)) >= 3;
  wire valid    = p <= max_p;
  wire in_frame = st_q inside {S_NORM, S_INC, S_DEC, S_NDF};
  wire size_mm  = ss != (cfg_vt2 ? 2'b10 : 2'b11);
  wire [3:0] lim   = (cfg_inv_limit == 4'd0) ? 4'd1 : cfg_inv_limit;
  wire [3:0] inv_n = (inv_q == 4'hF) ? inv_q : inv_q + 4'd1;

  always_comb begin
    st_d = st_q; ptr_d = ptr_out; cand_d = cand_q;
    ais_d = ais_q; cons_d = cons_q; inv_d = inv_q; mm_d = mm_q;
    size_d = size_alarm; inc_d = 1'b0; dec_d = 1'b0;
    if (word_vld) begin
      if (all_ones) begin
        ais_d = (ais_q == 2'd3) ? ais_q : ais_q + 2'd1;
        cons_d = '0; inv_d = '0;
        if (ais_d == 2'd3) st_d = S_AIS;
      end else begin
        ais_d = '0;
        if (size_mm) begin
          mm_d = (mm_q == 2'd3) ? mm_q : mm_q + 2'd1;
          if (mm_d == 2'd3) size_d = 1'b1;
        end else begin
          mm_d = '0; size_d = 1'b0;
        end
        if (ndf_hit && valid) begin
          st_d = S_NDF; ptr_d = p; cand_d = p; cons_d = 2'd1; inv_d = '0;
        end else if (in_frame && !ndf_hit && inc_hit) begin
          st_d = S_INC; inc_d = 1'b1; cons_d = '0; inv_d = '0;
          ptr_d = (ptr_out == max_p) ? '0 : ptr_out + 1'b1;
        end else if (in_frame && !ndf_hit && dec_hit) begin
          st_d = S_DEC; dec_d = 1'b1; cons_d = '0; inv_d = '0;
          ptr_d = (ptr_out == '0) ? max_p : ptr_out - 1'b1;
        end else if (valid && !ndf_hit) begin
          inv_d = '0;
          if (p == cand_q && cons_q != 2'd0)
            cons_d = (cons_q == 2'd3) ? cons_q : cons_q + 2'd1;
          else begin
            cand_d = p; cons_d = 2'd1;
          end
          if (cons_d == 2'd3) begin
            st_d = S_NORM; ptr_d = p;
          end
        end else begin
          cons_d = '0; inv_d = inv_n;
          if (inv_n >= lim) st_d = S_LOP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_LOP; ptr_out <= '0; cand_q <= '0;
      ais_q <= '0; cons_q <= '0; inv_q <= '0; mm_q <= '0;
      size_alarm <= 1'b0; inc_evt <= 1'b0; dec_evt <= 1'b0;
      ais_chg <= 1'b0; lop_chg <= 1'b0; size_chg <= 1'b0;
    end else begin
      st_q <= st_d; ptr_out <= ptr_d; cand_q <= cand_d;
      ais_q <= ais_d; cons_q <= cons_d; inv_q <= inv_d; mm_q <= mm_d;
      size_alarm <= size_d; inc_evt <= inc_d; dec_evt <= dec_d;
      ais_chg  <= (st_d == S_AIS) != (st_q == S_AIS);
      lop_chg  <= (st_d == S_LOP) != (st_q == S_LOP);
      size_chg <= size_d != size_alarm;
    end
  end

  assign state_out = st_q;
  assign ais_alarm = st_q == S_AIS;
  assign lop_alarm = st_q == S_LOP;
endmodule

// File: rtl/vt_ptr_interp_chk.sv
`timescale 1ns/1ps
module vt_ptr_interp_chk #(
  parameter int PW    = 10,
  parameter int MAX_A = 103,
  parameter int MAX_B = 139
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_vld,
  input logic          cfg_vt2,
  input logic [PW-1:0] ptr_out,
  input logic          inc_evt,
  input logic          dec_evt,
  input logic          ais_alarm,
  input logic          lop_alarm,
  input logic          size_alarm,
  input logic          ais_chg,
  input logic          lop_chg,
  input logic          size_chg
);
  wire [PW-1:0] max_p = cfg_vt2 ? PW'(MAX_B) : PW'(MAX_A);

  assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> ptr_out == (($past(ptr_out) == max_p) ? '0 : $past(ptr_out) + 1'b1));
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |-> ptr_out == (($past(ptr_out) == '0) ? max_p : $past(ptr_out) - 1'b1));
  assert_evt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_evt, dec_evt}));
  assert_alarm_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ais_alarm, lop_alarm}));
  assert_lop_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lop_chg == (lop_alarm != $past(lop_alarm)));
  assert_ais_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ais_chg == (ais_alarm != $past(ais_alarm)));
  assert_size_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    size_chg == (size_alarm != $past(size_alarm)));
  assert_size_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_alarm) |-> $past(word_vld));
  assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(ptr_out));
  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_out <= max_p);
endmodule

bind vt_ptr_interp vt_ptr_interp_chk #(.PW(PW), .MAX_A(MAX_A), .MAX_B(MAX_B)) i_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .cfg_vt2(cfg_vt2),
  .ptr_out(ptr_out), .inc_evt(inc_evt), .dec_evt(dec_evt),
  .ais_alarm(ais_alarm), .lop_alarm(lop_alarm), .size_alarm(size_alarm),
  .ais_chg(ais_chg), .lop_chg(lop_chg), .size_chg(size_chg));

// File: tb/test_vt_ptr_interp.sv
`timescale 1ns/1ps
module test_vt_ptr_interp;
  logic clk = 1'b0, rst_n = 1'b0, word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic cfg_vt2 = 1'b0, cfg_majority = 1'b1;
  logic [3:0] cfg_inv_limit = 4'd4;
  logic [9:0] ptr_out;
  logic [2:0] state_out;
  logic inc_evt, dec_evt, ais_alarm, lop_alarm, size_alarm, ais_chg, lop_chg, size_chg;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vt_ptr_interp i_vt_ptr_interp (.*);

  typedef struct packed {
    logic [2:0] st; logic [9:0] ptr;
    logic inc, dec, sz, lc, ac, sc;
  } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  function automatic logic [15:0] mk(input logic [3:0] n, input logic [1:0] s, input logic [9:0] p);
    return {n, s, p};
  endfunction

  task automatic send(input logic [15:0] w, input logic [2:0] st, input logic [9:0] p,
                      input logic inc, input logic dec, input logic sz,
                      input logic lc, input logic ac, input logic sc, input string tag);
    @(negedge clk);
    exp_q.push_back('{st, p, inc, dec, sz, lc, ac, sc});
    tag_q.push_back(tag);
    word_in = w; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  initial forever begin
    @(posedge clk);
    if (word_vld) begin
      exp_t e, a;
      string t;
      #5;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = '{state_out, ptr_out, inc_evt, dec_evt, size_alarm, lop_chg, ais_chg, size_chg};
      checks++;
      if (a != e || ais_alarm != (e.st == 3'd4) || lop_alarm != (e.st == 3'd5)) begin
        errors++;
        $display("FAIL %s actual st=%0d ptr=%0d inc=%b dec=%b sz=%b lc=%b ac=%b sc=%b expected st=%0d ptr=%0d inc=%b dec=%b sz=%b lc=%b ac=%b sc=%b",
          t, a.st, a.ptr, a.inc, a.dec, a.sz, a.lc, a.ac, a.sc,
          e.st, e.ptr, e.inc, e.dec, e.sz, e.lc, e.ac, e.sc);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (state_out != 3'd5 || ptr_out != 0 || !lop_alarm || ais_alarm || size_alarm ||
        inc_evt || dec_evt || lop_chg || ais_chg || size_chg) begin
      errors++;
      $display("FAIL R1 reset actual st=%0d ptr=%0d expected st=5 ptr=0", state_out, ptr_out);
    end
    // R2 acquisition
    send(mk(4'h6, 2'b11, 10'd50), 5, 0, 0,0,0,0,0,0, "R2 acq1");
    send(mk(4'h6, 2'b11, 10'd50), 5, 0, 0,0,0,0,0,0, "R2 acq2");
    send(mk(4'h6, 2'b11, 10'd50), 0, 50, 0,0,0,1,0,0, "R2 acq3 R11");
    // R3 increment
    send(mk(4'h6, 2'b11, 10'd50 ^ 10'h2AA), 1, 51, 1,0,0,0,0,0, "R3 inc");
    send(mk(4'h6, 2'b11, 10'd51), 1, 51, 0,0,0,0,0,0, "R2 after inc 1");
    send(mk(4'h6, 2'b11, 10'd51), 1, 51, 0,0,0,0,0,0, "R2 after inc 2");
    send(mk(4'h6, 2'b11, 10'd51), 0, 51, 0,0,0,0,0,0, "R2 after inc 3");
    // R4 decrement
    send(mk(4'h6, 2'b11, 10'd51 ^ 10'h155), 2, 50, 0,1,0,0,0,0, "R4 dec");
    // R5 voting rule
    send(mk(4'h6, 2'b11, 10'd50 ^ 10'h2D5), 2, 50, 0,0,0,0,0,0, "R5 majority rejects");
    @(negedge clk); cfg_majority = 1'b0;
    send(mk(4'h6, 2'b11, 10'd50 ^ 10'h2D5), 2, 49, 0,1,0,0,0,0, "R5 three-of-five accepts");
    @(negedge clk); cfg_majority = 1'b1;
    // R6 new data flag
    send(mk(4'h9, 2'b11, 10'd80), 3, 80, 0,0,0,0,0,0, "R6 ndf exact");
    send(mk(4'h8, 2'b11, 10'd90), 3, 90, 0,0,0,0,0,0, "R6 ndf 3of4");
    send(mk(4'h6, 2'b11, 10'd90), 3, 90, 0,0,0,0,0,0, "R2 after ndf 1");
    send(mk(4'h6, 2'b11, 10'd90), 0, 90, 0,0,0,0,0,0, "R2 after ndf 2");
    // wrap cases
    send(mk(4'h9, 2'b11, 10'd0), 3, 0, 0,0,0,0,0,0, "R6 ndf zero");
    send(mk(4'h6, 2'b11, 10'h155), 2, 103, 0,1,0,0,0,0, "R4 wrap at 0");
    send(mk(4'h6, 2'b11, 10'd103 ^ 10'h2AA), 1, 0, 1,0,0,0,0,0, "R3 wrap at max");
    // R10 size check
    send(mk(4'h6, 2'b10, 10'd0), 1, 0, 0,0,0,0,0,0, "R10 mm1");
    send(mk(4'h6, 2'b10, 10'd0), 1, 0, 0,0,0,0,0,0, "R10 mm2");
    send(mk(4'h6, 2'b10, 10'd0), 0, 0, 0,0,1,0,0,1, "R10 mm3 R11");
    send(mk(4'h6, 2'b11, 10'd0), 0, 0, 0,0,0,0,0,1, "R10 clear R11");
    send(mk(4'h6, 2'b10, 10'd0), 0, 0, 0,0,0,0,0,0, "R10 mm1 again");
    send(mk(4'h6, 2'b10, 10'd0), 0, 0, 0,0,0,0,0,0, "R10 mm2 again");
    send(mk(4'h6, 2'b11, 10'd0), 0, 0, 0,0,0,0,0,0, "R10 run broken");
    // type 2
    @(negedge clk); cfg_vt2 = 1'b1;
    send(mk(4'h6, 2'b10, 10'd130), 0, 0, 0,0,0,0,0,0, "R2 vt2 1");
    send(mk(4'h6, 2'b10, 10'd130), 0, 0, 0,0,0,0,0,0, "R2 vt2 2");
    send(mk(4'h6, 2'b10, 10'd130), 0, 130, 0,0,0,0,0,0, "R2 vt2 3");
    // R8 loss of pointer
    send(mk(4'h6, 2'b10, 10'd140), 0, 130, 0,0,0,0,0,0, "R8 inv1");
    send(mk(4'h6, 2'b10, 10'd140), 0, 130, 0,0,0,0,0,0, "R8 inv2");
    send(mk(4'h6, 2'b10, 10'd140), 0, 130, 0,0,0,0,0,0, "R8 inv3");
    send(mk(4'h6, 2'b10, 10'd140), 5, 130, 0,0,0,1,0,0, "R8 inv4 R11");
    // R7 AIS
    send(16'hFFFF, 5, 130, 0,0,0,0,0,0, "R7 ones1");
    send(16'hFFFF, 5, 130, 0,0,0,0,0,0, "R7 ones2");
    send(16'hFFFF, 4, 130, 0,0,0,1,1,0, "R7 ones3 R11");
    send(mk(4'h6, 2'b10, 10'd130), 4, 130, 0,0,0,0,0,0, "R7 exit1");
    send(mk(4'h6, 2'b10, 10'd130), 4, 130, 0,0,0,0,0,0, "R7 exit2");
    send(mk(4'h6, 2'b10, 10'd130), 0, 130, 0,0,0,0,1,0, "R7 exit3 R11");
    // R8 other limit
    @(negedge clk); cfg_inv_limit = 4'd2;
    send(mk(4'h6, 2'b10, 10'd140), 0, 130, 0,0,0,0,0,0, "R8 lim2 inv1");
    send(mk(4'h6, 2'b10, 10'd140), 5, 130, 0,0,0,1,0,0, "R8 lim2 inv2");
    // R9 justification ignored in LOP
    send(mk(4'h6, 2'b10, 10'd130 ^ 10'h2AA), 5, 130, 0,0,0,0,0,0, "R9 inc in LOP");
    // R12 pointer held between words
    repeat (3) @(negedge clk);
    checks++;
    if (ptr_out != 10'd130) begin
      errors++;
      $display("FAIL R12 hold actual %0d expected 130", ptr_out);
    end
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule